// File: doc/BRIEF.md
# Complement-Shadowed Memory with Error Changeover

This block is a single-port synchronous RAM that stores every word twice: once as written and once bit-inverted in a second array. A write, full or byte-masked, updates both arrays on the same clock edge. A read fetches both copies on the same edge and requires each bit of the shadow to be the opposite of the matching bit of the primary. The primary copy is returned with the same one-cycle latency a plain synchronous RAM would have.

When the two copies disagree, the block raises a read-error strobe alongside the returned data. It also sets a sticky changeover request for the redundancy controller, and records the address of the first failing read. Any number of flipped bits in either array is caught, because a correct word pair XORs to all ones. A fault-injection port toggles one chosen bit of one chosen array so that the detection path can be tested in place.

Top module: `dim_mem_guard`

## Requirements
- R1: After reset every word reads back as zero with no read error, and `rdata`, `rvalid`, `rd_err`, `chg_req` and `fail_addr` are all zero.
- R2: A request with `req`=1 and `we`=0 sampled at clock edge N gives `rvalid`=1 and the primary word in `rdata` right after edge N, for exactly that cycle. Back-to-back reads are supported.
- R3: On a write, byte lane i (bits 8i+7 down to 8i) of both arrays changes only when `be[i]`=1. The shadow array receives the bitwise inverse of those bytes, so a later read reports no error.
- R4: A fault injected with `inj_inv`=0 toggles bit `inj_bit` of the primary word at `inj_addr` on the next edge. A later read of that word returns the toggled data with `rd_err`=1 in the same cycle as `rvalid`.
- R5: A fault injected with `inj_inv`=1 toggles the shadow copy only. A later read returns the unchanged primary data with `rd_err`=1.
- R6: `chg_req` rises on the edge after the first cycle with `rd_err`=1 and stays high until reset.
- R7: `fail_addr` takes the address of the first failing read when `chg_req` rises, and later failures leave it unchanged.
- R8: `rd_err` is never high without `rvalid`. A write request produces no `rvalid`.
- R9: When an injection and a write hit the same word on the same edge, the write is applied first and the bit toggle after it. A write with all byte enables set repairs an injected word. A masked write leaves a fault in an unwritten lane detectable.
- R10: Asserting reset mid-run clears `chg_req`, `fail_addr` and both arrays back to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| be | input | DATA_W/8 | Byte enables for writes |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Primary copy of the read word |
| rvalid | output | 1 | Read data valid |
| rd_err | output | 1 | Copies disagreed on this read |
| chg_req | output | 1 | Sticky changeover request |
| fail_addr | output | ADDR_W | Address of the first failing read |
| inj_en | input | 1 | Toggle one stored bit |
| inj_inv | input | 1 | 0 = primary array, 1 = shadow array |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_bit | input | $clog2(DATA_W) | Bit to toggle |

## Verification
The bench targets faults in each array separately. A checker that only tests for inequality, or returns the shadow copy, would either miss shadow faults or deliver inverted data. It also checks that a second failure at another address leaves the recorded address alone; a latch that reloads on every error would overwrite it. Masked writes over a corrupted word are exercised because a design that refreshes the whole shadow word would silently hide a fault in an unwritten lane. An injection and a write landing on the same word on one edge pin down the ordering.

// File: rtl/dim_pkg.sv
package dim_pkg;
  // Selects which array a fault injection targets.
  typedef enum logic {
    ARR_PRIMARY = 1'b0,
    ARR_SHADOW  = 1'b1
  } arr_sel_e;
endpackage

// File: rtl/dim_array.sv
module dim_array #(
  parameter int   ADDR_W   = 6,
  parameter int   DATA_W   = 32,
  parameter int   BYTE_W   = 8,
  parameter logic RST_ONES = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W/BYTE_W-1:0]  be,
  input  logic [DATA_W-1:0]         wr_word,
  input  logic                      flip_en,
  input  logic [ADDR_W-1:0]         flip_addr,
  input  logic [$clog2(DATA_W)-1:0] flip_bit,
  output logic [DATA_W-1:0]         rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = DATA_W / BYTE_W;
  localparam logic [DATA_W-1:0] RST_WORD = {DATA_W{RST_ONES}};

  logic [DATA_W-1:0] mem_q   [DEPTH];
  logic [DATA_W-1:0] mem_nxt [DEPTH];
  logic [DATA_W-1:0] rd_nxt;
  logic              mem_ce;

  // Next state: byte-masked write first, then the injected toggle.
  always_comb begin
    mem_nxt = mem_q;
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) mem_nxt[addr][b*BYTE_W +: BYTE_W] = wr_word[b*BYTE_W +: BYTE_W];
      end
    end
    if (flip_en) mem_nxt[flip_addr][flip_bit] = ~mem_nxt[flip_addr][flip_bit];
  end

  assign mem_ce = wr_en | flip_en;
  assign rd_nxt = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_WORD;
    end else if (mem_ce) begin
      mem_q <= mem_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word <= RST_WORD;
    else if (rd_en) rd_word <= rd_nxt;
  end
endmodule

// File: rtl/dim_compare.sv
module dim_compare #(
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] prim_word,
  input  logic [DATA_W-1:0] shad_word,
  output logic              mismatch
);
  logic [DATA_W-1:0] pair_xor;

  // A healthy pair has every bit opposite, so the XOR is all ones.
  always_comb begin
    pair_xor = prim_word ^ shad_word;
    mismatch = valid & ~(&pair_xor);
  end
endmodule

// File: rtl/dim_err_latch.sv
module dim_err_latch #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_in,
  input  logic [ADDR_W-1:0] err_addr,
  output logic              chg_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              chg_nxt;
  logic              cap_en;

  always_comb begin
    cap_en  = err_in & ~chg_q;
    chg_nxt = chg_q | err_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (cap_en) addr_q <= err_addr;
  end

  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |=> chg_q); // R6
  AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |=> $stable(addr_q)); // R7
endmodule

// File: rtl/dim_mem_guard.sv
module dim_mem_guard #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W/8-1:0]       be,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rvalid,
  output logic                      rd_err,
  output logic                      chg_req,
  output logic [ADDR_W-1:0]         fail_addr,
  input  logic                      inj_en,
  input  logic                      inj_inv,
  input  logic [ADDR_W-1:0]         inj_addr,
  input  logic [$clog2(DATA_W)-1:0] inj_bit
);
  import dim_pkg::*;

  localparam int BYTE_W = 8;

  logic              wr_go, rd_go;
  logic              flip_prim, flip_shad;
  logic [DATA_W-1:0] prim_q, shad_q;
  logic [ADDR_W-1:0] rd_addr_q;
  arr_sel_e          inj_sel;

  always_comb begin
    wr_go     = req & we;
    rd_go     = req & ~we;
    inj_sel   = arr_sel_e'(inj_inv);
    flip_prim = inj_en & (inj_sel == ARR_PRIMARY);
    flip_shad = inj_en & (inj_sel == ARR_SHADOW);
  end

  dim_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .RST_ONES(1'b0)) u_prim (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .rd_en(rd_go), .addr(addr), .be(be),
    .wr_word(wdata), .flip_en(flip_prim), .flip_addr(inj_addr), .flip_bit(inj_bit),
    .rd_word(prim_q)
  );

  dim_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .RST_ONES(1'b1)) u_shad (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .rd_en(rd_go), .addr(addr), .be(be),
    .wr_word(~wdata), .flip_en(flip_shad), .flip_addr(inj_addr), .flip_bit(inj_bit),
    .rd_word(shad_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rd_addr_q <= addr;
    end
  end

  dim_compare #(.DATA_W(DATA_W)) u_cmp (
    .valid(rvalid), .prim_word(prim_q), .shad_word(shad_q), .mismatch(rd_err)
  );

  dim_err_latch #(.ADDR_W(ADDR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .err_in(rd_err), .err_addr(rd_addr_q),
    .chg_q(chg_req), .addr_q(fail_addr)
  );

  assign rdata = prim_q;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R2
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !rvalid); // R8
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rvalid); // R8
  AST_ERR_RAISES_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> chg_req); // R6
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !chg_req) |=> (fail_addr == $past(rd_addr_q))); // R7
endmodule

// File: tb/dim_mem_guard_tb.sv
module dim_mem_guard_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [NB-1:0] be;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid, rd_err, chg_req;
  logic [AW-1:0] fail_addr;
  logic          inj_en, inj_inv;
  logic [AW-1:0] inj_addr;
  logic [4:0]    inj_bit;

  always #10 clk = ~clk; // 50 MHz

  dim_mem_guard #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .be(be), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .rd_err(rd_err), .chg_req(chg_req), .fail_addr(fail_addr),
    .inj_en(inj_en), .inj_inv(inj_inv), .inj_addr(inj_addr), .inj_bit(inj_bit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // Reference model state
  logic [DW-1:0] m_p [DEPTH];
  logic [DW-1:0] m_s [DEPTH];
  logic          m_chg;
  logic [AW-1:0] m_fa;
  logic          pend_err;
  logic [AW-1:0] pend_addr;
  logic          e_rv, e_err;
  logic [DW-1:0] e_rd;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_p[i] = '0;
      m_s[i] = '1;
    end
    m_chg = 0; m_fa = '0; pend_err = 0; pend_addr = '0;
  endtask

  task automatic idle_inputs();
    req = 0; we = 0; addr = '0; be = '0; wdata = '0;
    inj_en = 0; inj_inv = 0; inj_addr = '0; inj_bit = '0;
  endtask

  task automatic step();
    @(posedge clk);
    if (pend_err) begin
      if (!m_chg) m_fa = pend_addr;
      m_chg = 1;
    end
    e_rv  = req && !we;
    e_rd  = m_p[addr];
    e_err = e_rv && ((m_p[addr] ^ m_s[addr]) != '1);
    pend_err  = e_err;
    pend_addr = addr;
    if (req && we) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) begin
          m_p[addr][b*8 +: 8] = wdata[b*8 +: 8];
          m_s[addr][b*8 +: 8] = ~wdata[b*8 +: 8];
        end
      end
    end
    if (inj_en) begin
      if (inj_inv) m_s[inj_addr][inj_bit] = ~m_s[inj_addr][inj_bit];
      else         m_p[inj_addr][inj_bit] = ~m_p[inj_addr][inj_bit];
    end
    @(negedge clk);
    chk("rvalid R2 R8", rvalid, e_rv);
    if (e_rv) chk("rdata R2", rdata, e_rd);
    chk("rd_err R4 R5 R8", rd_err, e_err);
    chk("chg_req R6", chg_req, m_chg);
    chk("fail_addr R7", fail_addr, m_fa);
    idle_inputs();
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [NB-1:0] m);
    req = 1; we = 1; addr = AW'(a); wdata = d; be = m;
    step();
  endtask

  task automatic rd(input int a);
    req = 1; we = 0; addr = AW'(a);
    step();
  endtask

  task automatic inj(input int a, input int bitn, input logic shadow);
    inj_en = 1; inj_addr = AW'(a); inj_bit = 5'(bitn); inj_inv = shadow;
    step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("reset rdata R1 R10", rdata, 0);
    chk("reset rvalid R1 R10", rvalid, 0);
    chk("reset chg_req R1 R10", chg_req, 0);
    chk("reset fail_addr R1 R10", fail_addr, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    tag = "R1";
    do_reset();
    for (int i = 0; i < DEPTH; i++) rd(i);

    tag = "R2";
    wr(3, 32'hDEADBEEF, 4'hF);
    wr(4, 32'h12345678, 4'hF);
    rd(3); rd(4); rd(3);
    wr(63, 32'hFFFFFFFF, 4'hF);
    idle_inputs(); step();
    rd(63);

    tag = "R3";
    wr(7, 32'hAABBCCDD, 4'hF);
    wr(7, 32'h11223344, 4'b0101);
    rd(7);
    wr(7, 32'h55667788, 4'b1000);
    rd(7);
    wr(8, 32'hCAFEF00D, 4'b0000);
    rd(8);

    tag = "R8";
    wr(9, 32'h0F0F0F0F, 4'hF);
    idle_inputs(); step();

    tag = "R4";
    inj(3, 3, 1'b0);
    rd(4);
    rd(3);
    idle_inputs(); step();
    rd(3);

    tag = "R7";
    inj(9, 0, 1'b1);
    rd(9);
    idle_inputs(); step();

    tag = "R10";
    do_reset();
    rd(3); rd(9);

    tag = "R5";
    wr(10, 32'h80000001, 4'hF);
    inj(10, 31, 1'b1);
    rd(10);
    idle_inputs(); step();

    tag = "R9";
    do_reset();
    wr(12, 32'h13579BDF, 4'hF);
    inj(12, 5, 1'b0);
    wr(12, 32'h2468ACE0, 4'hF);
    rd(12);
    inj(12, 20, 1'b1);
    wr(12, 32'h00000099, 4'b0001);
    rd(12);
    idle_inputs(); step();
    do_reset();
    // write and injection on the same word and edge: write first, then toggle
    req = 1; we = 1; addr = AW'(20); wdata = 32'h00FF00FF; be = 4'hF;
    inj_en = 1; inj_addr = AW'(20); inj_bit = 5'd8; inj_inv = 1'b0;
    step();
    rd(20);
    idle_inputs(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule